// File: doc/BRIEF.md
# Transfer Speed Downgrade Controller

This block watches a storage link for transmission errors and decides when it is time to slow the link down. It counts error pulses inside a time window measured in timebase ticks. When the count goes past a threshold inside one window, it picks the next slower setting. On a serial link it first lowers the physical-layer speed level. Once that option is used up, or on a parallel link, it steps the transfer mode down. Ultra DMA modes drop one at a time. Ultra DMA 0 drops to PIO 4, and PIO 4 drops to PIO 3. At PIO 3 or below the block makes no further request and raises a warning instead. Operation continues at that setting.

The block neither programs the link nor issues commands. It presents one request at a time on a valid/ready-style handshake. The request outputs stay asserted, with a stable payload, until `req_ack` is seen high in a cycle where a request is up. There is no other back-pressure. Error pulses that arrive while a request is waiting, or while a reapply is owed, are dropped.

A device reset wipes the device's transfer-mode setting. After each `reset_done` pulse the block therefore asks for the mode to be written again. The mode it asks for is the last one it chose, or the current mode if it has chosen none. Mode codes are 4 bits wide: 0–4 stand for PIO 0–4, and 8–14 stand for Ultra DMA 0–6. Speed level 1 is the slowest usable speed, and 0 means no limit is set.

Top module: `xfer_downgrade`

## Requirements
- R1: After `rst_n` is released, no request output is high and `floor_warn` is low.
- R2: A downgrade fires on the accepted error pulse that takes the window count above `ERR_LIMIT` (default 3). The request is visible one cycle after that pulse. `ERR_LIMIT` pulses alone never fire.
- R3: After `WIN_TICKS` tick pulses the error count returns to zero. Errors counted before that expiry no longer contribute to a trigger.
- R4: When `is_sata` is high and `cur_spd` is not 1, the downgrade is a speed request of `cur_spd`−1. When `cur_spd` is 0, the request is the top level minus one, which is 2 for a 2-bit level.
- R5: Otherwise, Ultra DMA codes 9–14 step down to the code minus one, and code 15 is treated as code 14.
- R6: Otherwise, code 8 (Ultra DMA 0) steps to code 4 (PIO 4).
- R7: Otherwise, codes 4–7 step to code 3 (PIO 3).
- R8: Otherwise (codes 0–3), no request is raised. Instead `floor_warn` rises and stays high until `rst_n`.
- R9: A request keeps its valid and payload until acknowledged. At most one of `spd_req_valid` and `mode_req_valid` is high at a time.
- R10: Errors that arrive while a request or a reapply is pending are ignored. The count is cleared by each downgrade.
- R11: A `reset_done` pulse leads to `mode_req_valid` and `reapply_req` high, with `mode_req` equal to the last chosen mode, or to `cur_mode` if no mode has been chosen. If another request is pending, the reapply follows in the cycle after that request's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 1 | One pulse per transmission error |
| tick | input | 1 | Timebase pulse for the error window |
| is_sata | input | 1 | Link is serial and its speed can be limited |
| cur_spd | input | SPD_W | Current speed level (0 = no limit, 1 = slowest) |
| cur_mode | input | 4 | Current transfer mode code |
| reset_done | input | 1 | Device reset completed pulse |
| req_ack | input | 1 | Ready: accepts the pending request |
| spd_req_valid | output | 1 | Speed request pending |
| spd_req | output | SPD_W | Requested speed level |
| mode_req_valid | output | 1 | Mode request pending (downgrade or reapply) |
| mode_req | output | 4 | Requested mode code |
| reapply_req | output | 1 | The pending mode request is a reapply after reset |
| floor_warn | output | 1 | Lowest mode reached, no further downgrade |

## Verification
Every result appears one register stage after its cause. A triggering error or a `reset_done` pulse driven in one cycle shows on the request outputs after the next rising edge. An acknowledge clears the request at that same edge. A reapply deferred behind a pending request appears one edge after the acknowledge. The bench drives inputs just after a falling edge and checks outputs at the following falling edge, so each check lands exactly one edge after its stimulus. Checks of held requests and of a sticky warning are made again several cycles later.

// File: rtl/xdg_pkg.sv
package xdg_pkg;
  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_SPD     = 2'd1,
    REQ_MODE    = 2'd2,
    REQ_REAPPLY = 2'd3
  } req_kind_e;

  localparam logic [3:0] MODE_PIO3  = 4'd3;
  localparam logic [3:0] MODE_PIO4  = 4'd4;
  localparam logic [3:0] MODE_UDMA0 = 4'd8;
  localparam logic [3:0] MODE_UDMA6 = 4'd14;
  localparam logic [3:0] MODE_TOP   = 4'd15;
endpackage

// File: rtl/xdg_window.sv
module xdg_window #(
  parameter int ERR_LIMIT = 3,
  parameter int WIN_TICKS = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic err_in,
  output logic trip
);
  localparam int CW = $clog2(ERR_LIMIT + 1);
  localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LIM = CW'(ERR_LIMIT);
  localparam logic [WW-1:0] WLAST = WW'(WIN_TICKS - 1);

  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = tick && (win_q == WLAST);
  assign trip   = err_in && !expire && (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      if (tick) win_q <= expire ? '0 : win_q + 1'b1;
      if (expire)                         cnt_q <= CW'(err_in);
      else if (trip)                      cnt_q <= '0;
      else if (err_in && (cnt_q != LIM))  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/xdg_step.sv
module xdg_step
  import xdg_pkg::*;
#(
  parameter int SPD_W = 2
) (
  input  logic             is_sata,
  input  logic [SPD_W-1:0] cur_spd,
  input  logic [3:0]       cur_mode,
  output logic             do_spd,
  output logic             do_mode,
  output logic             at_floor,
  output logic [SPD_W-1:0] nxt_spd,
  output logic [3:0]       nxt_mode
);
  localparam logic [SPD_W-1:0] SPD_MAX = '1;
  localparam logic [SPD_W-1:0] SPD_MIN = SPD_W'(1);

  always_comb begin
    do_spd   = 1'b0;
    do_mode  = 1'b0;
    at_floor = 1'b0;
    nxt_spd  = cur_spd;
    nxt_mode = cur_mode;
    if (is_sata && (cur_spd != SPD_MIN)) begin
      do_spd  = 1'b1;
      nxt_spd = (cur_spd == '0) ? SPD_MAX - 1'b1 : cur_spd - 1'b1;
    end else if (cur_mode[3]) begin
      do_mode = 1'b1;
      if (cur_mode == MODE_UDMA0)    nxt_mode = MODE_PIO4;
      else if (cur_mode == MODE_TOP) nxt_mode = MODE_UDMA6;
      else                           nxt_mode = cur_mode - 4'd1;
    end else if (cur_mode >= MODE_PIO4) begin
      do_mode  = 1'b1;
      nxt_mode = MODE_PIO3;
    end else begin
      at_floor = 1'b1;
    end
  end
endmodule

// File: rtl/xdg_req.sv
module xdg_req
  import xdg_pkg::*;
#(
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  input  logic             do_spd,
  input  logic             do_mode,
  input  logic             at_floor,
  input  logic [SPD_W-1:0] nxt_spd,
  input  logic [3:0]       nxt_mode,
  input  logic [3:0]       cur_mode,
  input  logic             reset_done,
  input  logic             req_ack,
  output req_kind_e        kind_q,
  output logic [SPD_W-1:0] spd_q,
  output logic [3:0]       mode_q,
  output logic             floor_q,
  output logic             accept
);
  logic [3:0] chosen_q;
  logic       chosen_v;
  logic       owed_q;

  assign accept = (kind_q == REQ_NONE) && !owed_q && !reset_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q   <= REQ_NONE;
      spd_q    <= '0;
      mode_q   <= '0;
      floor_q  <= 1'b0;
      chosen_q <= '0;
      chosen_v <= 1'b0;
      owed_q   <= 1'b0;
    end else if (kind_q == REQ_NONE) begin
      if (reset_done || owed_q) begin
        kind_q <= REQ_REAPPLY;
        mode_q <= chosen_v ? chosen_q : cur_mode;
        owed_q <= 1'b0;
      end else if (trip) begin
        if (do_spd) begin
          kind_q <= REQ_SPD;
          spd_q  <= nxt_spd;
        end else if (do_mode) begin
          kind_q   <= REQ_MODE;
          mode_q   <= nxt_mode;
          chosen_q <= nxt_mode;
          chosen_v <= 1'b1;
        end else if (at_floor) begin
          floor_q <= 1'b1;
        end
      end
    end else begin
      if (req_ack)    kind_q <= REQ_NONE;
      if (reset_done) owed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/xfer_downgrade.sv
module xfer_downgrade
  import xdg_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int WIN_TICKS = 900,
  parameter int SPD_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_pulse,
  input  logic             tick,
  input  logic             is_sata,
  input  logic [SPD_W-1:0] cur_spd,
  input  logic [3:0]       cur_mode,
  input  logic             reset_done,
  input  logic             req_ack,
  output logic             spd_req_valid,
  output logic [SPD_W-1:0] spd_req,
  output logic             mode_req_valid,
  output logic [3:0]       mode_req,
  output logic             reapply_req,
  output logic             floor_warn
);
  logic             accept, trip;
  logic             do_spd, do_mode, at_floor;
  logic [SPD_W-1:0] nxt_spd;
  logic [3:0]       nxt_mode;
  req_kind_e        kind;

  xdg_window #(.ERR_LIMIT(ERR_LIMIT), .WIN_TICKS(WIN_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .err_in(err_pulse && accept), .trip(trip)
  );

  xdg_step #(.SPD_W(SPD_W)) u_step (
    .is_sata(is_sata), .cur_spd(cur_spd), .cur_mode(cur_mode),
    .do_spd(do_spd), .do_mode(do_mode), .at_floor(at_floor),
    .nxt_spd(nxt_spd), .nxt_mode(nxt_mode)
  );

  xdg_req #(.SPD_W(SPD_W)) u_req (
    .clk(clk), .rst_n(rst_n), .trip(trip),
    .do_spd(do_spd), .do_mode(do_mode), .at_floor(at_floor),
    .nxt_spd(nxt_spd), .nxt_mode(nxt_mode), .cur_mode(cur_mode),
    .reset_done(reset_done), .req_ack(req_ack),
    .kind_q(kind), .spd_q(spd_req), .mode_q(mode_req),
    .floor_q(floor_warn), .accept(accept)
  );

  assign spd_req_valid  = (kind == REQ_SPD);
  assign mode_req_valid = (kind == REQ_MODE) || (kind == REQ_REAPPLY);
  assign reapply_req    = (kind == REQ_REAPPLY);
endmodule

// File: rtl/xdg_chk.sv
module xdg_chk #(
  parameter int SPD_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_pulse,
  input logic             req_ack,
  input logic             spd_req_valid,
  input logic [SPD_W-1:0] spd_req,
  input logic             mode_req_valid,
  input logic [3:0]       mode_req,
  input logic             reapply_req,
  input logic             floor_warn
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(spd_req_valid && mode_req_valid));

  p_spd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spd_req_valid && !req_ack |=> spd_req_valid && $stable(spd_req));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_valid && !req_ack |=> mode_req_valid && $stable(mode_req) && $stable(reapply_req));

  p_reapply_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reapply_req |-> mode_req_valid);

  p_floor_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    floor_warn |=> floor_warn);

  p_spd_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spd_req_valid |-> spd_req != '0);

  p_spd_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spd_req_valid) |-> $past(err_pulse));

  p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_valid && !reapply_req |->
      (mode_req >= 4'd3) && (mode_req <= 4'd14) && !(mode_req inside {4'd5, 4'd6, 4'd7}));
endmodule

bind xfer_downgrade xdg_chk #(.SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .req_ack(req_ack),
  .spd_req_valid(spd_req_valid), .spd_req(spd_req),
  .mode_req_valid(mode_req_valid), .mode_req(mode_req),
  .reapply_req(reapply_req), .floor_warn(floor_warn)
);

// File: tb/sim_xfer_downgrade.sv
`timescale 1ns/1ps
module sim_xfer_downgrade;
  localparam int LIM = 3;
  localparam int WIN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_pulse = 1'b0, tick = 1'b0, is_sata = 1'b0;
  logic [1:0] cur_spd = 2'd0;
  logic [3:0] cur_mode = 4'd0;
  logic       reset_done = 1'b0, req_ack = 1'b0;
  logic       spd_req_valid, mode_req_valid, reapply_req, floor_warn;
  logic [1:0] spd_req;
  logic [3:0] mode_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xfer_downgrade #(.ERR_LIMIT(LIM), .WIN_TICKS(WIN), .SPD_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .tick(tick),
    .is_sata(is_sata), .cur_spd(cur_spd), .cur_mode(cur_mode),
    .reset_done(reset_done), .req_ack(req_ack),
    .spd_req_valid(spd_req_valid), .spd_req(spd_req),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .reapply_req(reapply_req), .floor_warn(floor_warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic errs(input int n);
    for (int i = 0; i < n; i++) begin
      err_pulse = 1'b1;
      @(negedge clk);
      err_pulse = 1'b0;
    end
  endtask

  task automatic ack();
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
  endtask

  task automatic rdone();
    reset_done = 1'b1;
    @(negedge clk);
    reset_done = 1'b0;
  endtask

  // expected step: 0 none/floor, 1 speed, 2 mode
  function automatic int exp_kind(input bit s, input int spd, input int md);
    if (s && spd != 1) return 1;
    if (md >= 4) return 2;
    return 0;
  endfunction

  function automatic int exp_spd(input int spd);
    return (spd == 0) ? 2 : spd - 1;
  endfunction

  function automatic int exp_mode(input int md);
    if (md == 8) return 4;
    if (md == 15) return 14;
    if (md > 8) return md - 1;
    return 3;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 spd_valid", spd_req_valid, 0);
    chk("R1 mode_valid", mode_req_valid, 0);
    chk("R1 reapply", reapply_req, 0);
    chk("R1 floor", floor_warn, 0);

    // sweep every link type, speed level and mode code
    for (int s = 0; s < 2; s++) begin
      for (int spd = 0; spd < 4; spd++) begin
        for (int md = 0; md < 16; md++) begin
          int k, em;
          do_reset();
          is_sata = s[0]; cur_spd = spd[1:0]; cur_mode = md[3:0];
          k = exp_kind(s[0], spd, md);
          errs(LIM);
          chk("R2 below limit", spd_req_valid | mode_req_valid, 0);
          errs(1);
          chk("R9 spd_valid", spd_req_valid, k == 1);
          chk("R9 mode_valid", mode_req_valid, k == 2);
          chk("R2 reapply", reapply_req, 0);
          if (k == 1) chk("R4 spd", spd_req, exp_spd(spd));
          if (k == 2) begin
            if (md == 8)      chk("R6 mode", mode_req, 4);
            else if (md >= 8) chk("R5 mode", mode_req, exp_mode(md));
            else              chk("R7 mode", mode_req, 3);
          end
          chk("R8 floor", floor_warn, k == 0);
          if (k != 0) begin
            idle(3);
            chk("R9 held", spd_req_valid | mode_req_valid, 1);
            if (k == 1) chk("R9 spd stable", spd_req, exp_spd(spd));
            else        chk("R9 mode stable", mode_req, exp_mode(md));
            ack();
            chk("R9 cleared", spd_req_valid | mode_req_valid, 0);
          end
          em = (k == 2) ? exp_mode(md) : md;
          rdone();
          chk("R11 reapply", reapply_req, 1);
          chk("R11 mode_valid", mode_req_valid, 1);
          chk("R11 mode", mode_req, em);
          ack();
          chk("R11 cleared", mode_req_valid, 0);
          if (k == 0) begin
            idle(4);
            chk("R8 sticky", floor_warn, 1);
          end
        end
      end
    end

    // R3: window expiry discards earlier errors
    do_reset();
    is_sata = 1'b0; cur_spd = 2'd0; cur_mode = 4'd10;
    errs(LIM);
    tick = 1'b1;
    idle(WIN);
    tick = 1'b0;
    errs(LIM);
    chk("R3 no trip after expiry", mode_req_valid, 0);
    errs(1);
    chk("R3 trip in new window", mode_req_valid, 1);
    chk("R3 mode", mode_req, 9);
    ack();

    // R10: errors during a pending request are dropped
    do_reset();
    is_sata = 1'b1; cur_spd = 2'd3; cur_mode = 4'd12;
    errs(LIM + 1);
    chk("R10 spd req", spd_req_valid, 1);
    errs(6);
    chk("R10 still pending", spd_req_valid, 1);
    ack();
    errs(LIM);
    chk("R10 count cleared", spd_req_valid, 0);
    errs(1);
    chk("R10 trips again", spd_req_valid, 1);
    chk("R10 spd", spd_req, 2);

    // R11: reset during a pending request defers the reapply
    rdone();
    chk("R11 deferred spd", spd_req_valid, 1);
    chk("R11 deferred no reapply", reapply_req, 0);
    errs(LIM + 1);
    chk("R10 owed ignores errs", spd_req_valid, 1);
    ack();
    chk("R11 gap", spd_req_valid | mode_req_valid, 0);
    idle(1);
    chk("R11 late reapply", reapply_req, 1);
    chk("R11 late mode", mode_req, 12);
    ack();
    idle(1);
    chk("R10 no trip from owed errs", spd_req_valid | mode_req_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule